// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block sits in front of an on-chip scratchpad built from 16 single-port banks, each one 32-bit word wide. It accepts a group of 16 lane requests at a time. Each lane carries an active flag, a word address, a write flag and write data. The bank of a word is its address modulo the bank count, so consecutive words sit in consecutive banks.

Every cycle, each bank serves one distinct address. All pending lanes that name that address are served together, so a read of one address shared by many lanes is a single broadcast access. Lanes that name different addresses in the same bank are spread over successive cycles. A group therefore takes as many cycles as the largest number of distinct addresses that fall in any one bank. While a group is in service `busy` is high. When the group finishes, a one-cycle `done` pulse marks the per-lane read data as valid.

Top module: `sp_conflict_arb`

## Requirements
- R1: The bank of a lane is the low 4 bits of its word address and the row inside that bank is the remaining upper bits. Addresses 16 apart therefore share a bank, and addresses 0 to 15 fall in 16 different banks.
- R2: A group whose active lanes all hit different banks is served in one cycle. This covers stride-1 addressing and any one-to-one permutation of banks. `done` is high in the cycle after the first clock edge following the accepting edge.
- R3: When every active lane reads the identical address, the read is broadcast. The group takes one cycle and every lane returns the same word.
- R4: The number of service cycles equals the maximum, over all banks, of the number of distinct addresses the active lanes name in that bank. Stride 2 takes 2 cycles, stride 8 takes 8, and 16 lanes in one bank at 16 different addresses take 16.
- R5: A reading lane returns the word as it stood before the group was accepted. When several lanes in one group write the same address, the data of the highest-numbered writing lane is what the memory keeps.
- R6: A request presented while `busy` is high is ignored. It does not change the results of the group in service and it does not change the memory.
- R7: `done` is a single-cycle pulse in the cycle where `busy` has just fallen. `rd_data` stays stable from that point until the next group is accepted.
- R8: Lanes that are inactive, or that write, return zero on their `rd_data` slot.
- R9: A group with no active lane is accepted and completes with zero service cycles. `done` is high in the cycle right after the accepting edge, `busy` never rises, and the memory is unchanged.
- R10: While reset is asserted and after it is released, `busy` and `done` are low and `rd_data` is zero until a group is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request group is presented; taken when `busy` is low |
| lane_act | input | 16 | Per-lane active flag |
| lane_addr | input | 128 | Per-lane word address, 8 bits each, lane i at bits [8i+7:8i] |
| lane_we | input | 16 | Per-lane write flag (1 = write, 0 = read) |
| lane_wdata | input | 512 | Per-lane write data, 32 bits each, lane i at bits [32i+31:32i] |
| busy | output | 1 | Group in service; new requests are ignored |
| done | output | 1 | One-cycle pulse: group complete, `rd_data` valid |
| rd_data | output | 512 | Per-lane read result, 32 bits each, same lane packing |

## Verification
A group is accepted on the edge where `req_valid` is high and `busy` is low. With k service cycles, `done` is seen k edges later; for an empty group it is seen right after the accepting edge. Inputs are driven on the falling edge. The bench counts rising edges from the accepting edge and samples `done` on each falling edge, so the measured count equals the expected cycle count that a bench function derives from the distinct addresses per bank. Read data is compared in the same falling-edge sample where `done` is first seen, and again one cycle later, when `done` must be low and `rd_data` unchanged.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned SP_LANES  = 16;
  localparam int unsigned SP_BANKS  = 16;
  localparam int unsigned SP_ADDR_W = 8;
  localparam int unsigned SP_DATA_W = 32;
endpackage

// File: rtl/sp_bank_pick.sv
// One bank's pick logic: the lowest-numbered pending lane in this bank sets
// the address served this cycle; every pending lane naming that address is
// served along with it.
module sp_bank_pick #(
  parameter int unsigned LANES   = 16,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned BANK_W  = 4,
  parameter int unsigned BANK_ID = 0,
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned ROW_W  = ADDR_W - BANK_W
) (
  input  logic [LANES-1:0]             pend,
  input  logic [LANES-1:0][ADDR_W-1:0] addr,
  input  logic [LANES-1:0]             we,
  output logic [LANES-1:0]             served,
  output logic                         hit,
  output logic                         wr_en,
  output logic [LANE_W-1:0]            wr_lane,
  output logic [ROW_W-1:0]             row
);
  logic [LANES-1:0]  in_bank;
  logic [ADDR_W-1:0] lead_addr;

  always_comb begin
    hit       = 1'b0;
    lead_addr = '0;
    for (int i = 0; i < LANES; i++) begin
      in_bank[i] = pend[i] && (addr[i][BANK_W-1:0] == BANK_W'(BANK_ID));
    end
    for (int i = 0; i < LANES; i++) begin
      if (in_bank[i] && !hit) begin
        hit       = 1'b1;
        lead_addr = addr[i];
      end
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_lane = '0;
    for (int i = 0; i < LANES; i++) begin
      served[i] = in_bank[i] && (addr[i] == lead_addr);
      // ascending scan: the highest-numbered writer wins
      if (served[i] && we[i]) begin
        wr_en   = 1'b1;
        wr_lane = LANE_W'(i);
      end
    end
    row = lead_addr[ADDR_W-1:BANK_W];
  end
endmodule

// File: rtl/sp_bank_store.sv
// One scratchpad bank: combinational read, clocked write, no reset on storage.
module sp_bank_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ROW_W  = 4,
  localparam int unsigned DEPTH = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  assign rdata = mem[row];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[row] <= wdata;
    end
  end
endmodule

// File: rtl/sp_conflict_arb.sv
module sp_conflict_arb #(
  parameter int unsigned LANES  = sp_pkg::SP_LANES,
  parameter int unsigned BANKS  = sp_pkg::SP_BANKS,
  parameter int unsigned ADDR_W = sp_pkg::SP_ADDR_W,
  parameter int unsigned DATA_W = sp_pkg::SP_DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [LANES-1:0]         lane_act,
  input  logic [LANES*ADDR_W-1:0]  lane_addr,
  input  logic [LANES-1:0]         lane_we,
  input  logic [LANES*DATA_W-1:0]  lane_wdata,
  output logic                     busy,
  output logic                     done,
  output logic [LANES*DATA_W-1:0]  rd_data
);
  localparam int unsigned BANK_W = $clog2(BANKS);
  localparam int unsigned ROW_W  = ADDR_W - BANK_W;
  localparam int unsigned LANE_W = $clog2(LANES);

  // captured request
  logic [LANES-1:0]             pend_q, pend_n;
  logic [LANES-1:0]             we_q, we_n;
  logic [LANES-1:0][ADDR_W-1:0] addr_q, addr_n;
  logic [LANES-1:0][DATA_W-1:0] wd_q, wd_n;
  logic [LANES-1:0][DATA_W-1:0] rd_q, rd_n;
  logic                         done_q, done_n;
  logic                         accept;
  logic                         cap_en;

  // per-bank service
  logic [LANES-1:0]  bank_served [BANKS];
  logic              bank_hit    [BANKS];
  logic              bank_wr     [BANKS];
  logic [LANE_W-1:0] bank_wlane  [BANKS];
  logic [ROW_W-1:0]  bank_row    [BANKS];
  logic [DATA_W-1:0] bank_rd     [BANKS];
  logic [LANES-1:0]  served_all;

  assign busy    = |pend_q;
  assign done    = done_q;
  assign rd_data = rd_q;
  assign accept  = req_valid && !busy;
  assign cap_en  = accept;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] wsel;
    assign wsel = wd_q[bank_wlane[b]];

    sp_bank_pick #(
      .LANES(LANES), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BANK_ID(b)
    ) u_pick (
      .pend    (pend_q),
      .addr    (addr_q),
      .we      (we_q),
      .served  (bank_served[b]),
      .hit     (bank_hit[b]),
      .wr_en   (bank_wr[b]),
      .wr_lane (bank_wlane[b]),
      .row     (bank_row[b])
    );

    sp_bank_store #(
      .DATA_W(DATA_W), .ROW_W(ROW_W)
    ) u_store (
      .clk   (clk),
      .wr_en (bank_wr[b]),
      .row   (bank_row[b]),
      .wdata (wsel),
      .rdata (bank_rd[b])
    );
  end

  always_comb begin
    served_all = '0;
    for (int b = 0; b < BANKS; b++) begin
      served_all = served_all | bank_served[b];
    end
  end

  // next state
  always_comb begin
    pend_n = pend_q & ~served_all;
    we_n   = we_q;
    addr_n = addr_q;
    wd_n   = wd_q;
    rd_n   = rd_q;
    done_n = busy && (pend_n == '0);
    for (int i = 0; i < LANES; i++) begin
      if (served_all[i] && !we_q[i]) begin
        rd_n[i] = bank_rd[addr_q[i][BANK_W-1:0]];
      end
    end
    if (accept) begin
      pend_n = lane_act;
      we_n   = lane_we & lane_act;
      addr_n = lane_addr;
      wd_n   = lane_wdata;
      rd_n   = '0;
      done_n = (lane_act == '0);
    end
  end

  // control and result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      done_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      pend_q <= pend_n;
      done_q <= done_n;
      rd_q   <= rd_n;
    end
  end

  // request capture registers, loaded only on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= '0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (cap_en) begin
      we_q   <= we_n;
      addr_q <= addr_n;
      wd_q   <= wd_n;
    end
  end

  // every cycle with work outstanding retires at least one lane
  assert_progress_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (served_all != '0));

  // only pending lanes can be served
  assert_served_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (served_all & ~pend_q) == '0);

  // while busy, no new lane may join the pending set
  assert_holdoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((pend_q & ~$past(pend_q)) == '0));

  // completion pulse coincides with the end of service
  assert_done_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // results held while idle and no new group arrives
  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> $stable(rd_q));
endmodule

// File: tb/sim_sp_conflict_arb.sv
module sim_sp_conflict_arb;
  localparam int L = 16;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [L-1:0] lane_act = '0;
  logic [L*AW-1:0] lane_addr = '0;
  logic [L-1:0] lane_we = '0;
  logic [L*DW-1:0] lane_wdata = '0;
  logic busy, done;
  logic [L*DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  bit [DW-1:0] mdl [256];
  bit [L-1:0]  t_act;
  bit [AW-1:0] t_addr [L];
  bit [L-1:0]  t_we;
  bit [DW-1:0] t_wd [L];

  sp_conflict_arb u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .lane_act(lane_act),
    .lane_addr(lane_addr), .lane_we(lane_we), .lane_wdata(lane_wdata),
    .busy(busy), .done(done), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_cycles();
    int mx = 0;
    for (int b = 0; b < 16; b++) begin
      int n = 0;
      for (int i = 0; i < L; i++) begin
        bit dup = 0;
        if (!t_act[i] || t_addr[i][3:0] != b[3:0]) continue;
        for (int j = 0; j < i; j++)
          if (t_act[j] && t_addr[j] == t_addr[i]) dup = 1;
        if (!dup) n++;
      end
      if (n > mx) mx = n;
    end
    return mx;
  endfunction

  // drive the stored group, measure cycles to done, compare results;
  // intr=1 presents a second group while busy (it must be ignored)
  task automatic run_group(input string tag, input bit intr);
    bit [DW-1:0] exp_rd [L];
    int ecyc = exp_cycles();
    int n = 0;
    logic [L*DW-1:0] snap;
    for (int i = 0; i < L; i++)
      exp_rd[i] = (t_act[i] && !t_we[i]) ? mdl[t_addr[i]] : '0;
    for (int i = 0; i < L; i++)
      if (t_act[i] && t_we[i]) mdl[t_addr[i]] = t_wd[i];
    @(negedge clk);
    req_valid = 1'b1;
    lane_act = t_act;
    lane_we = t_we;
    for (int i = 0; i < L; i++) begin
      lane_addr[i*AW +: AW] = t_addr[i];
      lane_wdata[i*DW +: DW] = t_wd[i];
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (intr) begin
      req_valid = 1'b1;
      lane_act = '1;
      lane_we = '1;
      for (int i = 0; i < L; i++) begin
        lane_addr[i*AW +: AW] = AW'(240 + i);
        lane_wdata[i*DW +: DW] = 32'hDEAD0000 + i;
      end
    end
    while (!done && n < 40) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(n == ecyc, {tag, " R4 cycle count"}, n, ecyc);
    for (int i = 0; i < L; i++) begin
      chk(rd_data[i*DW +: DW] == exp_rd[i],
          (t_act[i] && !t_we[i]) ? {tag, " R5 read data"} : {tag, " R8 zero slot"},
          rd_data[i*DW +: DW], exp_rd[i]);
    end
    snap = rd_data;
    @(negedge clk);
    chk(!done, {tag, " R7 done single pulse"}, done, 0);
    chk(rd_data == snap, {tag, " R7 rd_data held"}, rd_data[31:0], snap[31:0]);
  endtask

  task automatic clear_group();
    for (int i = 0; i < L; i++) begin
      t_addr[i] = '0;
      t_wd[i] = '0;
    end
    t_act = '0;
    t_we = '0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R10: reset values
    chk(!busy && !done, "R10 reset busy/done", {busy, done}, 0);
    chk(rd_data == '0, "R10 reset rd_data", rd_data[31:0], 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && rd_data == '0, "R10 after release", {busy, done}, 0);

    // fill memory with stride-1 writes (R1/R2 all banks distinct)
    for (int g = 0; g < 16; g++) begin
      clear_group();
      for (int i = 0; i < L; i++) begin
        t_act[i] = 1'b1; t_we[i] = 1'b1;
        t_addr[i] = AW'(g * 16 + i);
        t_wd[i] = $urandom;
      end
      run_group("R2 fill stride1", 0);
    end

    // R2: stride-1 read
    clear_group();
    for (int i = 0; i < L; i++) begin t_act[i] = 1; t_addr[i] = AW'(32 + i); end
    run_group("R2 stride1 read", 0);

    // R2: one-to-one permutation across banks, mixed rows
    clear_group();
    for (int i = 0; i < L; i++) begin
      t_act[i] = 1; t_addr[i] = AW'(((i * 5 + 3) % 16) + 16 * (i % 7));
    end
    run_group("R2 permutation", 0);

    // R4: stride 2 gives 2 cycles
    clear_group();
    for (int i = 0; i < L; i++) begin t_act[i] = 1; t_addr[i] = AW'(2 * i); end
    run_group("R4 stride2", 0);

    // R4: stride 8 gives 8 cycles
    clear_group();
    for (int i = 0; i < L; i++) begin t_act[i] = 1; t_addr[i] = AW'(8 * i); end
    run_group("R4 stride8", 0);

    // R1/R4: all lanes in bank 5, sixteen rows -> 16 cycles
    clear_group();
    for (int i = 0; i < L; i++) begin t_act[i] = 1; t_addr[i] = AW'(16 * i + 5); end
    run_group("R1 same bank 16 rows", 0);

    // R3: broadcast of one address
    clear_group();
    for (int i = 0; i < L; i++) begin t_act[i] = 1; t_addr[i] = 8'd77; end
    run_group("R3 broadcast", 0);

    // R5: same-address writes, highest lane wins; plus a reader of old value
    clear_group();
    t_act[0] = 1; t_addr[0] = 8'd99;
    for (int i = 2; i < 12; i++) begin
      t_act[i] = 1; t_we[i] = 1; t_addr[i] = 8'd99; t_wd[i] = 32'hA5A50000 + i;
    end
    run_group("R5 same-address writes", 0);
    clear_group();
    t_act[3] = 1; t_addr[3] = 8'd99;
    run_group("R5 winner readback", 0);

    // R9: empty group
    clear_group();
    run_group("R9 empty group", 0);

    // R6: request while busy is ignored; then read its addresses back
    clear_group();
    for (int i = 0; i < L; i++) begin t_act[i] = 1; t_addr[i] = AW'(8 * i + 1); end
    run_group("R6 busy group", 1);
    clear_group();
    for (int i = 0; i < L; i++) begin t_act[i] = 1; t_addr[i] = AW'(240 + i); end
    run_group("R6 ignored writes absent", 0);

    // random mix with frequent bank collisions
    for (int g = 0; g < 80; g++) begin
      clear_group();
      for (int i = 0; i < L; i++) begin
        t_act[i] = ($urandom % 4) != 0;
        t_we[i] = ($urandom % 4) == 0;
        t_addr[i] = AW'($urandom % 64);
        t_wd[i] = $urandom;
      end
      run_group("R4 random", 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule